// File: doc/BRIEF.md
# Super I/O Configuration Port

This block models the configuration side of a Super I/O device on an 8-bit I/O bus. It answers on an index/data register pair: a register number is written to the index port, then the selected register is read or written through the data port, which sits one address above the index port. The pair is placed at one of two base addresses, chosen by a strap input.

After reset the configuration space is locked. Software opens it by writing a fixed four-byte key to the index port. The last byte of the key depends on which base address the block occupies. Once open, software can read the chip identity and select a logical device. It can then program a global flash-control register and a 16-bit I/O base for the flash interface, which lives in one logical device. The stored base and the decoded control bits drive output pins continuously. A write to the exit register locks the space again. The programmed values are kept, so software must send the key again before it can reach them.

The bus protocol itself is not modelled. Each access is a single-cycle write or read strobe that carries its address and write data. Read data is registered and shows up on the cycle after the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: With the strap input low the index port is at 0x2E; with it high the index port is at 0x4E. The data port is always the index port plus one. Accesses to any other address have no effect, and a read of any other address returns 0xFF.
- R2: The block unlocks when four writes to the index port carry 0x87, 0x01, 0x55 and then a last byte in that order. The last byte is 0x55 when the strap is low and 0xAA when it is high. Writes to other addresses between key bytes do not disturb matching. The block is unlocked from the cycle after the fourth key write.
- R3: While locked, an index-port write that does not match the expected key byte restarts matching from the first key byte. If that mismatching byte is 0x87, it counts as a matched first byte.
- R4: While unlocked, register 0x20 reads 0x87 and register 0x21 reads 0x16.
- R5: While unlocked, a read of the index port returns the last register number written to it.
- R6: Register 0x07 is an 8-bit logical-device selector that reads back what was written.
- R7: Register 0x24 stores bits 5:0 and reads bits 7:6 as zero. Bit 0 drives the suspend output, bits 3:1 drive the three segment-enable outputs (bit 1 to segment 0), bit 4 drives the host-write-enable output and bit 5 drives the pin-select output. The outputs change on the cycle after the write.
- R8: When the selector holds 7, register 0x64 is the high byte and register 0x65 the low byte of the flash-interface base, which appears on the base output. Under any other selector value, both registers read 0x00 and writes to them are ignored.
- R9: While locked, reads of the index or data port return 0xFF. Data-port writes change no register, and index-port writes do not change the register number.
- R10: A data write to register 0x02 with bit 1 set locks the block from the next cycle and clears the register number to 0x00. Register 0x02 reads 0x00. All programmed values survive relocking.
- R11: Read data is registered and valid on the cycle after the read strobe. Unlisted register numbers read 0x00.
- R12: Reset leaves the block locked with key matching at the first byte. The register number, the selector, the control bits and the flash base are all zero, and the read data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Base strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_addr | input | 16 | I/O address of the access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |
| flash_base | output | 16 | Programmed flash-interface I/O base |
| fl_suspend | output | 1 | Flash suspend control bit |
| fl_seg_en | output | 3 | Address segment enables |
| fl_host_wr_en | output | 1 | Enables host-bus writes to serial flash |
| fl_pin_sel | output | 1 | Flash pin selection |

## Verification
The assertions assume that a write strobe and a read strobe never occur in the same cycle, and that the strap does not change while the block is running. They also assume that the address and write data are valid whenever a strobe is high. The bench keeps to these rules in three ways. Every access is a one-cycle pulse on a single strobe, and each pulse is followed by an idle cycle. The strap is changed only while reset is held. The accesses cover both base addresses, broken and restarted key sequences, writes to other addresses between key bytes, and relocking followed by a second unlock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef logic [7:0] byte_t;

  localparam int KEY_LEN = 4;

  // Register numbers
  localparam byte_t REG_EXIT   = 8'h02;
  localparam byte_t REG_LDN    = 8'h07;
  localparam byte_t REG_ID_HI  = 8'h20;
  localparam byte_t REG_ID_LO  = 8'h21;
  localparam byte_t REG_FLCTL  = 8'h24;
  localparam byte_t REG_BASE_H = 8'h64;
  localparam byte_t REG_BASE_L = 8'h65;

  localparam int    EXIT_BIT   = 1;
  localparam byte_t IDLE_READ  = 8'hFF;

  // Unlock key byte at position pos; the final byte depends on the strap
  function automatic byte_t key_byte(input int pos, input logic alt);
    case (pos)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      2:       key_byte = 8'h55;
      default: key_byte = alt ? 8'hAA : 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E
) (
  input  logic              strap_alt,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);

  logic [ADDR_W-1:0] idx_port;
  logic [ADDR_W-1:0] dat_port;
  logic              at_idx;
  logic              at_dat;

  always_comb begin
    idx_port = strap_alt ? BASE_HI : BASE_LO;
    dat_port = idx_port + ADDR_W'(1);
    at_idx   = (io_addr == idx_port);
    at_dat   = (io_addr == dat_port);
    idx_wr   = io_wr & at_idx;
    idx_rd   = io_rd & at_idx;
    dat_wr   = io_wr & at_dat;
    dat_rd   = io_rd & at_dat;
  end

endmodule

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  strap_alt,
  input  logic  idx_wr,
  input  byte_t wdata,
  input  logic  relock,
  output logic  unlocked
);

  localparam int POS_W = $clog2(KEY_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(KEY_LEN - 1);

  logic [POS_W-1:0]   pos_q;
  logic               unlocked_q;
  logic [KEY_LEN-1:0] hit;

  // One comparator per key position
  for (genvar k = 0; k < KEY_LEN; k++) begin : g_key
    assign hit[k] = (wdata == key_byte(k, strap_alt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      unlocked_q <= 1'b0;
    end else if (relock) begin
      pos_q      <= '0;
      unlocked_q <= 1'b0;
    end else if (!unlocked_q && idx_wr) begin
      if (hit[pos_q]) begin
        if (pos_q == LAST_POS) begin
          pos_q      <= '0;
          unlocked_q <= 1'b1;
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end else begin
        // a stray first key byte restarts the sequence already matched
        pos_q <= hit[0] ? POS_W'(1) : '0;
      end
    end
  end

  assign unlocked = unlocked_q;

  // R2: opening only follows an index write
  a_r2_open_after_index_write: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_q) |-> $past(idx_wr));

  // R2: the final key byte at the last position opens the block
  a_r2_last_key_opens: assert property (@(posedge clk) disable iff (rst)
    (!unlocked_q && !relock && idx_wr && pos_q == LAST_POS &&
     wdata == key_byte(KEY_LEN - 1, strap_alt)) |=> unlocked_q);

  // R3: a first key byte always leaves matching at position one
  a_r3_first_byte_restart: assert property (@(posedge clk) disable iff (rst)
    (!unlocked_q && !relock && idx_wr && wdata == key_byte(0, strap_alt))
    |=> (pos_q == POS_W'(1)));

  // R10: the exit write locks the block
  a_r10_relock: assert property (@(posedge clk) disable iff (rst)
    relock |=> !unlocked_q);

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter byte_t       FLASH_LDN = 8'h07,
  parameter int          SEG_N     = 3,
  localparam int         CTL_W     = SEG_N + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unlocked,
  input  logic             idx_wr,
  input  logic             dat_wr,
  input  byte_t            wdata,
  output byte_t            cfg_index,
  output byte_t            rd_val,
  output logic             relock,
  output logic [15:0]      flash_base,
  output logic [CTL_W-1:0] flash_ctl
);

  byte_t            idx_q;
  byte_t            ldn_q;
  byte_t            base_hi_q;
  byte_t            base_lo_q;
  logic [CTL_W-1:0] ctl_q;
  logic             wr_ok;
  logic             ldn_flash;

  assign wr_ok     = unlocked & dat_wr;
  assign ldn_flash = (ldn_q == FLASH_LDN);
  assign relock    = wr_ok && (idx_q == REG_EXIT) && wdata[EXIT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (relock) begin
      idx_q <= '0;
    end else if (unlocked && idx_wr) begin
      idx_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q     <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      ctl_q     <= '0;
    end else if (wr_ok) begin
      case (idx_q)
        REG_LDN:    ldn_q <= wdata;
        REG_FLCTL:  ctl_q <= wdata[CTL_W-1:0];
        REG_BASE_H: if (ldn_flash) base_hi_q <= wdata;
        REG_BASE_L: if (ldn_flash) base_lo_q <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (idx_q)
      REG_LDN:    rd_val = ldn_q;
      REG_ID_HI:  rd_val = CHIP_ID[15:8];
      REG_ID_LO:  rd_val = CHIP_ID[7:0];
      REG_FLCTL:  rd_val = {{(8 - CTL_W){1'b0}}, ctl_q};
      REG_BASE_H: rd_val = ldn_flash ? base_hi_q : 8'h00;
      REG_BASE_L: rd_val = ldn_flash ? base_lo_q : 8'h00;
      default:    rd_val = 8'h00;
    endcase
  end

  assign cfg_index  = idx_q;
  assign flash_base = {base_hi_q, base_lo_q};
  assign flash_ctl  = ctl_q;

  // R9: nothing programmed changes while locked
  a_r9_locked_no_change: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> ($stable(ctl_q) && $stable(base_hi_q) && $stable(base_lo_q) && $stable(ldn_q)));

  // R8: the base is held while another logical device is selected
  a_r8_other_ldn_base_held: assert property (@(posedge clk) disable iff (rst)
    !ldn_flash |=> $stable(flash_base));

  // R10: relocking returns the register number to zero
  a_r10_index_cleared: assert property (@(posedge clk) disable iff (rst)
    relock |=> (idx_q == 8'h00));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  FLASH_LDN = 8'h07,
  parameter int          SEG_N     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_alt,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [15:0]       flash_base,
  output logic              fl_suspend,
  output logic [SEG_N-1:0]  fl_seg_en,
  output logic              fl_host_wr_en,
  output logic              fl_pin_sel
);

  localparam int CTL_W = SEG_N + 3;

  logic             idx_wr, idx_rd, dat_wr, dat_rd;
  logic             unlocked;
  logic             relock;
  byte_t            cfg_index;
  byte_t            rd_val;
  byte_t            rdata_d;
  byte_t            rdata_q;
  logic [CTL_W-1:0] flash_ctl;

  sio_port_decode #(
    .ADDR_W (ADDR_W),
    .BASE_LO(BASE_LO),
    .BASE_HI(BASE_HI)
  ) i_decode (
    .strap_alt(strap_alt),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .idx_wr   (idx_wr),
    .idx_rd   (idx_rd),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd)
  );

  sio_key_seq i_key (
    .clk      (clk),
    .rst      (rst),
    .strap_alt(strap_alt),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .relock   (relock),
    .unlocked (unlocked)
  );

  sio_cfg_regs #(
    .CHIP_ID  (CHIP_ID),
    .FLASH_LDN(FLASH_LDN),
    .SEG_N    (SEG_N)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .unlocked  (unlocked),
    .idx_wr    (idx_wr),
    .dat_wr    (dat_wr),
    .wdata     (io_wdata),
    .cfg_index (cfg_index),
    .rd_val    (rd_val),
    .relock    (relock),
    .flash_base(flash_base),
    .flash_ctl (flash_ctl)
  );

  always_comb begin
    rdata_d = IDLE_READ;
    if (unlocked) begin
      if (dat_rd)      rdata_d = rd_val;
      else if (idx_rd) rdata_d = cfg_index;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= IDLE_READ;
    else     rdata_q <= rdata_d;
  end

  assign io_rdata      = rdata_q;
  assign fl_suspend    = flash_ctl[0];
  assign fl_seg_en     = flash_ctl[SEG_N:1];
  assign fl_host_wr_en = flash_ctl[SEG_N+1];
  assign fl_pin_sel    = flash_ctl[SEG_N+2];

  // R1: a single strobe per cycle is assumed
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_rd));

  // R9: locked data-port reads return all ones
  a_r9_locked_read_ff: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && !unlocked) |=> (io_rdata == 8'hFF));

  // R4: identity high byte
  a_r4_chip_id_hi: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && unlocked && cfg_index == REG_ID_HI) |=> (io_rdata == CHIP_ID[15:8]));

  // R11: with no read strobe the read data idles high
  a_r11_idle_ff: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> (io_rdata == 8'hFF));

endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

  logic        clk = 1'b0;
  logic        rst;
  logic        strap_alt;
  logic        io_wr;
  logic        io_rd;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [15:0] flash_base;
  logic        fl_suspend;
  logic [2:0]  fl_seg_en;
  logic        fl_host_wr_en;
  logic        fl_pin_sel;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk          (clk),
    .rst          (rst),
    .strap_alt    (strap_alt),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .flash_base   (flash_base),
    .fl_suspend   (fl_suspend),
    .fl_seg_en    (fl_seg_en),
    .fl_host_wr_en(fl_host_wr_en),
    .fl_pin_sel   (fl_pin_sel)
  );

  function automatic logic [15:0] idx_port();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00;
  endtask

  // driver: pushes the expected byte, then strobes the read
  task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic cfg_write(input logic [7:0] r, input logic [7:0] v);
    io_write(idx_port(), r);
    io_write(idx_port() + 16'd1, v);
  endtask

  task automatic cfg_read(input logic [7:0] r, input logic [7:0] e, input string tag);
    io_write(idx_port(), r);
    io_read(idx_port() + 16'd1, e, tag);
  endtask

  task automatic send_key();
    io_write(idx_port(), 8'h87);
    io_write(idx_port(), 8'h01);
    io_write(idx_port(), 8'h55);
    io_write(idx_port(), strap_alt ? 8'hAA : 8'h55);
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst = 1'b1; strap_alt = alt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: pops and compares one expected byte per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (io_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL read without expectation actual %h expected none", io_rdata);
        end else begin
          chk({8'h00, io_rdata}, {8'h00, exp_q.pop_front()}, tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; strap_alt = 1'b0; io_wr = 1'b0; io_rd = 1'b0;
    io_addr = 16'h0000; io_wdata = 8'h00;
    do_reset(1'b0);

    // R12 reset state
    @(negedge clk);
    chk(flash_base, 16'h0000, "R12 base after reset");
    chk({11'd0, fl_pin_sel, fl_host_wr_en, fl_seg_en, fl_suspend}, 16'h0000, "R12 control after reset");
    chk({8'h00, io_rdata}, 16'h00FF, "R12 read data after reset");

    // R9 locked reads
    io_read(16'h002F, 8'hFF, "R9 locked data read");
    io_read(16'h002E, 8'hFF, "R9 locked index read");

    // R2 unlock at 0x2E, R4 identity, R5 index read back
    send_key();
    cfg_read(8'h20, 8'h87, "R4 id high");
    cfg_read(8'h21, 8'h16, "R4 id low");
    io_read(16'h002E, 8'h21, "R5 index read back");
    io_read(16'h004F, 8'hFF, "R1 other port read");

    // R6 selector
    cfg_write(8'h07, 8'h07);
    cfg_read(8'h07, 8'h07, "R6 selector read back");

    // R8 flash base under the flash device
    cfg_write(8'h64, 8'h12);
    cfg_write(8'h65, 8'h34);
    chk(flash_base, 16'h1234, "R8 base output");
    cfg_read(8'h64, 8'h12, "R8 base high read");
    cfg_read(8'h65, 8'h34, "R8 base low read");
    cfg_write(8'h07, 8'h03);
    cfg_read(8'h64, 8'h00, "R8 other device reads zero");
    cfg_write(8'h64, 8'hFF);
    chk(flash_base, 16'h1234, "R8 other device write ignored");

    // R7 flash control
    cfg_write(8'h24, 8'hFF);
    chk({11'd0, fl_pin_sel, fl_host_wr_en, fl_seg_en, fl_suspend}, 16'h003F, "R7 all bits set");
    cfg_read(8'h24, 8'h3F, "R7 upper bits read zero");
    cfg_write(8'h24, 8'h2A);
    chk({13'd0, fl_seg_en}, 16'h0005, "R7 segment enables");
    chk({15'd0, fl_suspend}, 16'h0000, "R7 suspend clear");
    chk({15'd0, fl_host_wr_en}, 16'h0000, "R7 host write enable clear");
    chk({15'd0, fl_pin_sel}, 16'h0001, "R7 pin select");

    // R11 unlisted register, R10 exit register read
    cfg_read(8'h30, 8'h00, "R11 unlisted register");
    cfg_read(8'h02, 8'h00, "R10 exit register reads zero");

    // R10 relock
    cfg_write(8'h02, 8'h02);
    io_read(16'h002F, 8'hFF, "R10 locked after exit");

    // R9 locked writes ignored (index write 0x24 just breaks the key)
    io_write(16'h002E, 8'h24);
    io_write(16'h002F, 8'h00);
    chk({11'd0, fl_pin_sel, fl_host_wr_en, fl_seg_en, fl_suspend}, 16'h002A, "R9 locked write ignored");

    // R3 restart on stray first byte
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h01);
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h01);
    io_write(16'h002E, 8'h55);
    io_write(16'h002E, 8'h55);
    io_read(16'h002E, 8'h00, "R10 index cleared by relock");
    cfg_read(8'h24, 8'h2A, "R10 values kept over relock");
    cfg_read(8'h20, 8'h87, "R3 unlocked after restart");
    cfg_write(8'h02, 8'h02);

    // R2 wrong last byte keeps the block locked
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h01);
    io_write(16'h002E, 8'h55);
    io_write(16'h002E, 8'hAA);
    io_read(16'h002F, 8'hFF, "R2 wrong last byte stays locked");

    // R3 a mismatch midway forces a full restart
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h33);
    io_write(16'h002E, 8'h01);
    io_write(16'h002E, 8'h55);
    io_write(16'h002E, 8'h55);
    io_read(16'h002F, 8'hFF, "R3 mismatch restarts matching");

    // R2 writes to other addresses do not break the key
    io_write(16'h002E, 8'h87);
    io_write(16'h0080, 8'h00);
    io_write(16'h002E, 8'h01);
    io_write(16'h002F, 8'h11);
    io_write(16'h002E, 8'h55);
    io_write(16'h002E, 8'h55);
    cfg_read(8'h21, 8'h16, "R2 key with other writes between");

    // R1 and R2 at the alternate base
    do_reset(1'b1);
    io_write(16'h002E, 8'h87);
    io_write(16'h002E, 8'h01);
    io_write(16'h002E, 8'h55);
    io_write(16'h002E, 8'h55);
    io_read(16'h004F, 8'hFF, "R1 old port ignored at alternate base");
    send_key();
    cfg_read(8'h20, 8'h87, "R2 alternate key opens");
    io_read(16'h002F, 8'hFF, "R1 low base unused when strapped high");
    chk(flash_base, 16'h0000, "R12 base cleared by reset");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R11 pending reads actual %0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule